// File: doc/BRIEF.md
# Peer Doorbell and State Register Block

This block is the register front end that one node of a shared-memory communication fabric uses to talk to its peers. Software reaches it through a simple 32-bit register bus covering one page of address space. It finds its own node ID and the size of the peer group there. It rings a doorbell on another peer, publishes a 32-bit lifecycle state, and controls whether incoming notifications raise a local interrupt.

Doorbell writes are forwarded to the interconnect as one-cycle requests that carry a target and a vector. State writes are stored locally. They are forwarded as change notifications only when the value really differs from the one stored. Delivery events coming back from the interconnect pass through a two-state interrupt gate. Its states are IRQ_MUTED and IRQ_ARMED. The transition MUTED to ARMED happens on a control write with bit 0 set. The transition ARMED to MUTED happens on a control write with bit 0 clear, or on a delivery while the privileged one-shot input is high. Any offset that has no register reads as zero and ignores writes, so the whole page can be mapped into an unprivileged user's space.

Top module: `peer_doorbell_regs`

## Requirements
- R1: A read request is answered by `bus_rvalid` high for exactly one cycle, in the cycle after the request. Offset 00h returns `cfg_local_id` zero-extended, and offset 04h returns `cfg_max_peers` zero-extended.
- R2: An unbacked access reads 0 and a write to it changes nothing. Unbacked means an offset with `bus_addr[1:0]` not 00, or a word offset other than 00h, 04h, 08h, 0Ch or 10h.
- R3: The interrupt control register at 08h resets to 0. Bit 0 is read/write, and bits 31:1 always read 0.
- R4: A write to 0Ch produces `db_valid` for one cycle in the next cycle. `db_vector` comes from write data bits 15:0 and `db_target` from bits 31:16. A read of 0Ch returns 0.
- R5: The state register at 10h resets to 0. A write stores the full 32-bit value, and a read returns the stored value.
- R6: A state write raises `st_chg_valid` for one cycle in the next cycle, carrying the new value in `st_chg_value`, only if the new value differs from the stored one.
- R7: When `evt_in` is high at a clock edge while control bit 0 is 1, `irq_out` is high for one cycle after that edge. An event arriving while bit 0 is 0 is dropped and never raised later.
- R8: With `cfg_oneshot` high, every delivered interrupt clears control bit 0. With `cfg_oneshot` low, bit 0 stays set.
- R9: When a control write and an event fall on the same edge, the event is judged against the enable value held before that edge. The written bit then sets the new enable value, and it takes precedence over a one-shot clear.
- R10: Writes to offsets 00h and 04h have no effect on what they read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the register page |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data, 0 when not valid |
| cfg_local_id | input | 16 | This node's peer ID |
| cfg_max_peers | input | 17 | Peer group size, 2 to 65536 |
| cfg_oneshot | input | 1 | Privileged one-shot throttling enable |
| db_valid | output | 1 | Doorbell request pulse |
| db_target | output | 16 | Doorbell target peer ID |
| db_vector | output | 16 | Doorbell vector number |
| st_chg_valid | output | 1 | State change notification pulse |
| st_chg_value | output | 32 | New state value |
| evt_in | input | 1 | Incoming delivery event |
| irq_out | output | 1 | Local interrupt pulse |

## Verification
An incoming delivery event and a software write to the interrupt control register can land on the same clock edge. When that happens, the order in which the event is judged and the enable is updated decides whether an interrupt is lost or duplicated. The bench drives `evt_in` together with control writes of both polarities. It does this from both the armed and the muted state, and with one-shot mode on, so that the one-shot clear and the software write compete. A behavioural model applies the rule of R9 and is compared with `irq_out` and the read-back enable on every cycle.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned PEER_W  = 16;
    localparam int unsigned CNT_W   = PEER_W + 1;
    localparam int unsigned VEC_W   = DATA_W - PEER_W;

    typedef enum logic [2:0] {
        REG_ID,
        REG_MAXP,
        REG_INTCTL,
        REG_DOORBELL,
        REG_STATE,
        REG_NONE
    } reg_sel_e;

    typedef enum logic {
        IRQ_MUTED,
        IRQ_ARMED
    } irq_state_e;
endpackage

// File: rtl/pdr_bus_decode.sv
module pdr_bus_decode
    import pdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel,
    output logic              wr_stb,
    output logic              rd_stb
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    assign word_idx = bus_addr[ADDR_W-1:2];

    always_comb begin
        sel = REG_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if      (word_idx == IDX_W'(0)) sel = REG_ID;
            else if (word_idx == IDX_W'(1)) sel = REG_MAXP;
            else if (word_idx == IDX_W'(2)) sel = REG_INTCTL;
            else if (word_idx == IDX_W'(3)) sel = REG_DOORBELL;
            else if (word_idx == IDX_W'(4)) sel = REG_STATE;
            else                            sel = REG_NONE;
        end
    end

    assign wr_stb = bus_valid &&  bus_write;
    assign rd_stb = bus_valid && !bus_write;
endmodule

// File: rtl/pdr_irq_ctrl.sv
module pdr_irq_ctrl
    import pdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_bit,
    input  logic evt_in,
    input  logic oneshot,
    output logic enable,
    output logic irq_out
);
    irq_state_e state_q, state_d;
    logic       fire;
    logic       irq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_MUTED;
        else        state_q <= state_d;
    end

    // next-state logic: a software write decides the new enable
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_MUTED: begin
                if (ctl_wr && ctl_bit) state_d = IRQ_ARMED;
            end
            IRQ_ARMED: begin
                if (ctl_wr)                state_d = ctl_bit ? IRQ_ARMED : IRQ_MUTED;
                else if (evt_in && oneshot) state_d = IRQ_MUTED;
            end
            default: state_d = IRQ_MUTED;
        endcase
    end

    assign fire = (state_q == IRQ_ARMED) && evt_in;

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign enable  = (state_q == IRQ_ARMED);
    assign irq_out = irq_q;

    AST_IRQ_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(evt_in)); // R7
    AST_MUTED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_MUTED) |=> !irq_out); // R7
    AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && evt_in && oneshot && !ctl_wr) |=> !enable); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (enable == $past(ctl_bit))); // R9
endmodule

// File: rtl/pdr_state_reg.sv
module pdr_state_reg
    import pdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              chg_valid,
    output logic [DATA_W-1:0] chg_value
);
    logic [DATA_W-1:0] value_q;
    logic              chg_q;
    logic [DATA_W-1:0] chg_val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q   <= '0;
            chg_q     <= 1'b0;
            chg_val_q <= '0;
        end else begin
            chg_q <= 1'b0;
            if (wr) begin
                value_q <= wdata;
                if (wdata != value_q) begin
                    chg_q     <= 1'b1;
                    chg_val_q <= wdata;
                end
            end
        end
    end

    assign value     = value_q;
    assign chg_valid = chg_q;
    assign chg_value = chg_val_q;

    AST_NOTIFY_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (value != $past(value))); // R6
    AST_SAME_VALUE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata == value)) |=> !chg_valid); // R6
    AST_NOTIFY_CARRIES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (chg_value == value)); // R6
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
    import pdr_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       cfg_local_id,
    input  logic [16:0]       cfg_max_peers,
    input  logic              cfg_oneshot,
    output logic              db_valid,
    output logic [15:0]       db_target,
    output logic [15:0]       db_vector,
    output logic              st_chg_valid,
    output logic [31:0]       st_chg_value,
    input  logic              evt_in,
    output logic              irq_out
);
    reg_sel_e          sel;
    logic              wr_stb, rd_stb;
    logic              irq_en;
    logic [DATA_W-1:0] state_val;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              db_q;
    logic [PEER_W-1:0] db_tgt_q;
    logic [VEC_W-1:0]  db_vec_q;

    pdr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .sel       (sel),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb)
    );

    pdr_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (wr_stb && (sel == REG_INTCTL)),
        .ctl_bit (bus_wdata[0]),
        .evt_in  (evt_in),
        .oneshot (cfg_oneshot),
        .enable  (irq_en),
        .irq_out (irq_out)
    );

    pdr_state_reg u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_stb && (sel == REG_STATE)),
        .wdata     (bus_wdata),
        .value     (state_val),
        .chg_valid (st_chg_valid),
        .chg_value (st_chg_value)
    );

    // doorbell request register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_q     <= 1'b0;
            db_tgt_q <= '0;
            db_vec_q <= '0;
        end else begin
            db_q <= 1'b0;
            if (wr_stb && (sel == REG_DOORBELL)) begin
                db_q     <= 1'b1;
                db_tgt_q <= bus_wdata[DATA_W-1:VEC_W];
                db_vec_q <= bus_wdata[VEC_W-1:0];
            end
        end
    end

    // registered read path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_stb;
            rdata_q  <= '0;
            if (rd_stb) begin
                unique case (sel)
                    REG_ID:       rdata_q <= DATA_W'(cfg_local_id);
                    REG_MAXP:     rdata_q <= DATA_W'(cfg_max_peers);
                    REG_INTCTL:   rdata_q <= DATA_W'(irq_en);
                    REG_DOORBELL: rdata_q <= '0;
                    REG_STATE:    rdata_q <= state_val;
                    default:      rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rvalid = rvalid_q;
    assign bus_rdata  = rdata_q;
    assign db_valid   = db_q;
    assign db_target  = db_tgt_q;
    assign db_vector  = db_vec_q;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && !bus_write)); // R1
    AST_UNBACKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (sel == REG_NONE)) |=> (bus_rdata == '0)); // R2
    AST_INTCTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (sel == REG_INTCTL)) |=> (bus_rdata[31:1] == '0)); // R3
    AST_DB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(bus_valid && bus_write && (bus_addr[1:0] == 2'b00))); // R4
endmodule

// File: tb/peer_doorbell_regs_test.sv
`timescale 1ns/1ps
module peer_doorbell_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [15:0] cfg_local_id = 16'h0005;
    logic [16:0] cfg_max_peers = 17'h10000;
    logic        cfg_oneshot = 1'b0;
    logic        db_valid;
    logic [15:0] db_target, db_vector;
    logic        st_chg_valid;
    logic [31:0] st_chg_value;
    logic        evt_in = 1'b0;
    logic        irq_out;

    int    n_chk = 0;
    int    n_bad = 0;
    string phase = "R3 reset";

    always #2.5 clk = ~clk;

    peer_doorbell_regs #(.ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cfg_local_id(cfg_local_id), .cfg_max_peers(cfg_max_peers),
        .cfg_oneshot(cfg_oneshot),
        .db_valid(db_valid), .db_target(db_target), .db_vector(db_vector),
        .st_chg_valid(st_chg_valid), .st_chg_value(st_chg_value),
        .evt_in(evt_in), .irq_out(irq_out)
    );

    // behavioural reference model
    bit          m_en;
    int unsigned m_state;
    bit          e_rvalid, e_db, e_st, e_irq;
    int unsigned e_rdata, e_st_val;
    int unsigned e_tgt, e_vec;

    function automatic int unsigned ref_read(logic [11:0] a);
        if (a[1:0] != 2'b00) return 0;
        case (a)
            12'h000: return int'(cfg_local_id);
            12'h004: return int'(cfg_max_peers);
            12'h008: return m_en ? 1 : 0;
            12'h010: return m_state;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_state = 0;
            e_rvalid = 0; e_rdata = 0; e_db = 0; e_st = 0; e_irq = 0;
            e_st_val = 0; e_tgt = 0; e_vec = 0;
        end else begin
            bit wr, nx_en;
            wr = bus_valid && bus_write;
            e_rvalid = bus_valid && !bus_write;
            e_rdata  = e_rvalid ? ref_read(bus_addr) : 0;
            e_db = 0;
            if (wr && bus_addr == 12'h00C) begin
                e_db = 1; e_tgt = bus_wdata >> 16; e_vec = bus_wdata & 32'hFFFF;
            end
            e_st = 0;
            if (wr && bus_addr == 12'h010) begin
                if (bus_wdata != m_state) begin e_st = 1; e_st_val = bus_wdata; end
                m_state = bus_wdata;
            end
            e_irq = evt_in && m_en;
            nx_en = m_en;
            if (e_irq && cfg_oneshot) nx_en = 0;
            if (wr && bus_addr == 12'h008) nx_en = bus_wdata[0];
            m_en = nx_en;
        end
    end

    task automatic chk(string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, got, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("rvalid (R1)", bus_rvalid, e_rvalid);
            chk("rdata", bus_rdata, e_rdata);
            chk("db_valid (R4)", db_valid, e_db);
            if (e_db) begin
                chk("db_target (R4)", db_target, e_tgt);
                chk("db_vector (R4)", db_vector, e_vec);
            end
            chk("st_chg_valid (R6)", st_chg_valid, e_st);
            if (e_st) chk("st_chg_value (R6)", st_chg_value, e_st_val);
            chk("irq_out (R7)", irq_out, e_irq);
        end
    end

    task automatic cyc(bit v, bit w, logic [11:0] a, logic [31:0] d, bit ev);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; evt_in = ev;
    endtask
    task automatic wr(logic [11:0] a, logic [31:0] d); cyc(1, 1, a, d, 0); endtask
    task automatic rd(logic [11:0] a);                 cyc(1, 0, a, 0, 0); endtask
    task automatic ev();                               cyc(0, 0, 0, 0, 1); endtask
    task automatic idle();                             cyc(0, 0, 0, 0, 0); endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 R5 reset values
        rd(12'h008); rd(12'h010); rd(12'h00C);
        phase = "R1 config read";
        rd(12'h000); rd(12'h004);
        cfg_local_id = 16'hBEEF; cfg_max_peers = 17'd2;
        rd(12'h000); rd(12'h004);
        phase = "R10 config write ignored";
        wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'h1234_5678);
        rd(12'h000); rd(12'h004);
        phase = "R2 unbacked";
        wr(12'h014, 32'hFFFF_FFFF); rd(12'h014); rd(12'h800);
        wr(12'h00E, 32'h0001_0001); wr(12'h011, 32'hDEAD_BEEF);
        rd(12'h011); rd(12'h010); rd(12'h00A); rd(12'hFFC);
        phase = "R3 interrupt control";
        wr(12'h008, 32'hFFFF_FFFF); rd(12'h008);
        wr(12'h008, 32'hFFFF_FFFE); rd(12'h008);
        phase = "R4 doorbell";
        wr(12'h00C, 32'h0003_0007); wr(12'h00C, 32'hFFFF_0000);
        wr(12'h00C, 32'h0000_FFFF); rd(12'h00C); idle();
        phase = "R5 R6 state";
        wr(12'h010, 32'h0000_00A5); wr(12'h010, 32'h0000_00A5);
        rd(12'h010); wr(12'h010, 32'h8000_0000); wr(12'h010, 32'h0);
        wr(12'h010, 32'h0); rd(12'h010);
        phase = "R7 gating";
        ev(); ev(); idle();
        wr(12'h008, 1); ev(); ev(); ev(); idle(); rd(12'h008);
        phase = "R8 one-shot";
        cfg_oneshot = 1'b1;
        ev(); ev(); idle(); rd(12'h008);
        wr(12'h008, 1); ev(); idle(); ev(); rd(12'h008);
        cfg_oneshot = 1'b0;
        wr(12'h008, 1); ev(); rd(12'h008);
        phase = "R9 same-edge control write and event";
        cfg_oneshot = 1'b1;
        wr(12'h008, 1);
        cyc(1, 1, 12'h008, 32'h1, 1); rd(12'h008);
        cyc(1, 1, 12'h008, 32'h0, 1); rd(12'h008);
        cyc(1, 1, 12'h008, 32'h1, 1); idle(); rd(12'h008);
        cfg_oneshot = 1'b0;
        cyc(1, 1, 12'h008, 32'h0, 1); ev(); rd(12'h008);
        phase = "R6 R7 state write beside event";
        wr(12'h008, 1);
        cyc(1, 1, 12'h010, 32'h55, 1); cyc(1, 1, 12'h010, 32'h55, 1); rd(12'h010);
        idle(); idle();
        summary();
        $finish;
    end
endmodule